// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the stream of column addresses that a synchronous DRAM controller issues over the following clocks. A request gives a starting column, a burst length code and an ordering flag. The block then produces one column address per clock, together with a valid flag and a flag that marks the final beat. In sequential ordering the low bits count upward and wrap inside the aligned block. In interleaved ordering the low bits are the start bits XORed with the beat number. A full-page setting keeps counting through every column of the row until it is stopped.

A stop input ends a running burst. A new legal request replaces a running burst on any cycle. A request that is not legal is ignored. The controller is built around three named states: `ST_IDLE`, `ST_FIXED` (a burst of 1, 2, 4 or 8 beats) and `ST_PAGE` (a full-page burst). The transitions are:
- LOAD_FIX (any state to `ST_FIXED` on a legal fixed-length request)
- LOAD_PAGE (any state to `ST_PAGE` on a legal full-page request)
- ADVANCE (`ST_FIXED` or `ST_PAGE` stays put and the beat index increments)
- FINISH (`ST_FIXED` to `ST_IDLE` after the final beat)
- HALT (`ST_FIXED` or `ST_PAGE` to `ST_IDLE` on stop without a legal request)

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and after it is released, `col_vld`, `last_beat` and `col_out` are all zero until a legal request is taken. A request made during reset has no effect.
- R2: A legal request sampled on a rising edge makes `col_vld` high with `col_out` equal to `start_col` in the following cycle. The `len_sel` codes are: 0 for 1 beat, 1 for 2 beats, 2 for 4 beats, 3 for 8 beats and 7 for full page. `ilv`=0 selects sequential ordering and `ilv`=1 selects interleaved ordering.
- R3: In sequential ordering, beat k keeps the column bits above log2(BL) from `start_col`. Its low log2(BL) bits are (low bits of `start_col` + k) mod BL.
- R4: In interleaved ordering, beat k keeps the upper bits. Its low log2(BL) bits are the low bits of `start_col` XOR k.
- R5: A fixed-length burst with no stop and no new request presents exactly BL consecutive valid beats. `last_beat` is high on the final beat only, and `col_vld` is low in the next cycle.
- R6: A full-page burst steps through all 1024 columns sequentially, wrapping from 1023 to 0. It continues until stopped or replaced, and `last_beat` stays low throughout.
- R7: `stop` sampled high during a valid beat, with no legal request in the same cycle, makes `col_vld` low from the next cycle. `stop` while idle has no effect.
- R8: A legal request during a running burst abandons it. The next cycle shows the new `start_col` as beat 0 of the new length and ordering.
- R9: When a legal request and `stop` are sampled in the same cycle, the request wins and a new burst starts.
- R10: A request is ignored if it combines `ilv`=1 with code 7, or if it uses codes 4, 5 or 6. An idle block stays idle, and a running burst continues its sequence unchanged.
- R11: `col_out` is zero in every cycle in which `col_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request strobe |
| start_col | input | 10 | First column of the requested burst |
| len_sel | input | 3 | Burst length code |
| ilv | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop | input | 1 | Ends the running burst |
| col_out | output | 10 | Column address of the current beat |
| col_vld | output | 1 | Current beat is valid |
| last_beat | output | 1 | Current beat is the final one of a fixed burst |

## Verification
Each fault in the held base column, beat index or mask appears on `col_out` in the first cycle after the load or the step that corrupted it. A mask of the wrong width shows up at the first beat that crosses an aligned boundary, which is beat 1 when the start column sits at the top of its block. A state register stuck in the wrong state shows as `col_vld` staying high one beat too long, or as `last_beat` appearing during a full-page run, on the cycle where the length would have ended. Every beat of every burst is compared at the ports against a model built from the ordering rules. Full-page runs are carried past the 1023-to-0 wrap.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;
endpackage

// File: rtl/bcg_len_dec.sv
module bcg_len_dec #(
    parameter int                COL_W       = 10,
    parameter int                LEN_W       = 3,
    parameter int                FIX_LOG_MAX = 3,
    parameter logic [LEN_W-1:0]  PAGE_CODE   = 3'd7
) (
    input  logic [LEN_W-1:0] len_sel,
    input  logic             ilv,
    output logic [COL_W-1:0] mask,
    output logic             is_page,
    output logic             legal
);
    localparam int N_FIX = FIX_LOG_MAX + 1;

    logic [COL_W-1:0] fix_mask [N_FIX];
    logic [N_FIX-1:0] hit;

    // one mask entry per fixed length, generated from its log2 value
    generate
        for (genvar i = 0; i < N_FIX; i++) begin : g_fix
            assign fix_mask[i] = COL_W'((1 << i) - 1);
            assign hit[i]      = (len_sel == LEN_W'(i));
        end
    endgenerate

    always_comb begin
        mask    = '0;
        is_page = (len_sel == PAGE_CODE);
        for (int i = 0; i < N_FIX; i++) begin
            if (hit[i]) mask = mask | fix_mask[i];
        end
        if (is_page) mask = '1;
        // full page is only meaningful for the sequential order
        legal = (|hit) || (is_page && !ilv);
    end
endmodule

// File: rtl/bcg_fsm.sv
module bcg_fsm
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic             stop,
    input  logic             is_page,
    input  logic [COL_W-1:0] mask_in,
    input  logic [COL_W-1:0] start_col,
    input  logic             ilv,
    output bcg_state_e       state_q,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] beat_q,
    output logic [COL_W-1:0] mask_q,
    output logic             ilv_q
);
    bcg_state_e       state_d;
    logic [COL_W-1:0] base_d, beat_d, mask_d;
    logic             ilv_d;

    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        beat_d  = beat_q;
        mask_d  = mask_q;
        ilv_d   = ilv_q;
        if (start_ok) begin
            // LOAD_FIX / LOAD_PAGE: a legal request wins over everything
            state_d = is_page ? ST_PAGE : ST_FIXED;
            base_d  = start_col;
            beat_d  = '0;
            mask_d  = mask_in;
            ilv_d   = ilv;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_FIXED: begin
                    if (stop || beat_q == mask_q) begin
                        // HALT or FINISH
                        state_d = ST_IDLE;
                        base_d  = '0;
                        beat_d  = '0;
                        mask_d  = '0;
                        ilv_d   = 1'b0;
                    end else begin
                        // ADVANCE
                        beat_d = beat_q + 1'b1;
                    end
                end
                ST_PAGE: begin
                    if (stop) begin
                        // HALT
                        state_d = ST_IDLE;
                        base_d  = '0;
                        beat_d  = '0;
                        mask_d  = '0;
                        ilv_d   = 1'b0;
                    end else begin
                        // ADVANCE, wraps through every column
                        beat_d = beat_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
            mask_q  <= mask_d;
            ilv_q   <= ilv_d;
        end
    end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
    parameter int COL_W = 10
) (
    input  logic             active,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] low_seq, low_ilv, low_sel;

    always_comb begin
        // sequential: add inside the aligned block, carry out is dropped by mask
        low_seq = ((base & mask) + beat) & mask;
        // interleaved: beat index flips the low bits
        low_ilv = (base ^ beat) & mask;
        low_sel = ilv ? low_ilv : low_seq;
        col     = active ? ((base & ~mask) | low_sel) : '0;
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W       = 10,
    parameter int LEN_W       = 3,
    parameter int FIX_LOG_MAX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [LEN_W-1:0] len_sel,
    input  logic             ilv,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_vld,
    output logic             last_beat
);
    localparam logic [LEN_W-1:0] PAGE_CODE = {LEN_W{1'b1}};

    logic [COL_W-1:0] dec_mask;
    logic             dec_page, dec_legal, start_ok;
    bcg_state_e       state_q;
    logic [COL_W-1:0] base_q, beat_q, mask_q;
    logic             ilv_q;

    bcg_len_dec #(
        .COL_W(COL_W), .LEN_W(LEN_W), .FIX_LOG_MAX(FIX_LOG_MAX), .PAGE_CODE(PAGE_CODE)
    ) u_dec (
        .len_sel(len_sel), .ilv(ilv), .mask(dec_mask), .is_page(dec_page), .legal(dec_legal)
    );

    assign start_ok = start && dec_legal;

    bcg_fsm #(.COL_W(COL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .stop(stop),
        .is_page(dec_page), .mask_in(dec_mask), .start_col(start_col), .ilv(ilv),
        .state_q(state_q), .base_q(base_q), .beat_q(beat_q), .mask_q(mask_q), .ilv_q(ilv_q)
    );

    always_comb begin
        col_vld   = (state_q != ST_IDLE);
        last_beat = (state_q == ST_FIXED) && (beat_q == mask_q);
    end

    bcg_addr_map #(.COL_W(COL_W)) u_map (
        .active(col_vld), .base(base_q), .beat(beat_q), .mask(mask_q), .ilv(ilv_q), .col(col_out)
    );
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
    parameter int COL_W       = 10,
    parameter int LEN_W       = 3,
    parameter int FIX_LOG_MAX = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic [LEN_W-1:0] len_sel,
    input logic             ilv,
    input logic             stop,
    input logic [COL_W-1:0] col_out,
    input logic             col_vld,
    input logic             last_beat
);
    logic req_fix, req_page, req_ok;
    always_comb begin
        req_fix  = (32'(len_sel) <= FIX_LOG_MAX);
        req_page = (len_sel == {LEN_W{1'b1}}) && !ilv;
        req_ok   = start && (req_fix || req_page);
    end

    // R2
    load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ok |=> (col_vld && col_out == $past(start_col)));

    // R5
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> col_vld);

    // R5
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !req_ok) |=> !col_vld);

    // R5
    run_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld && !last_beat && !stop) |=> col_vld);

    // R6
    page_nolast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && req_page) |=> !last_beat);

    // R7
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld && stop && !req_ok) |=> !col_vld);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_vld && !req_ok) |=> !col_vld);

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !col_vld |-> (col_out == '0));
endmodule

bind burst_col_gen bcg_chk #(
    .COL_W(COL_W), .LEN_W(LEN_W), .FIX_LOG_MAX(FIX_LOG_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col), .len_sel(len_sel),
    .ilv(ilv), .stop(stop), .col_out(col_out), .col_vld(col_vld), .last_beat(last_beat)
);

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic       ilv = 1'b0;
    logic [2:0] len_sel = 3'd0;
    logic [9:0] start_col = 10'd0;
    logic [9:0] col_out;
    logic       col_vld, last_beat;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    burst_col_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col), .len_sel(len_sel),
        .ilv(ilv), .stop(stop), .col_out(col_out), .col_vld(col_vld), .last_beat(last_beat)
    );

    // {start column, length code, ordering}
    localparam logic [13:0] VEC [0:7] = '{
        {10'h005, 3'd3, 1'b0}, {10'h2F6, 3'd2, 1'b1}, {10'h13A, 3'd3, 1'b1}, {10'h3FF, 3'd1, 1'b0},
        {10'h0C4, 3'd0, 1'b0}, {10'h1D3, 3'd2, 1'b0}, {10'h0B5, 3'd3, 1'b1}, {10'h201, 3'd1, 1'b1}
    };

    function automatic int blen(input logic [2:0] l);
        return (l == 3'd7) ? 1024 : (1 << int'(l));
    endfunction

    function automatic logic [9:0] exp_col(input logic [9:0] s, input logic [2:0] l,
                                           input logic iv, input int k);
        int blk = blen(l);
        int sv  = int'(s);
        int lo  = sv % blk;
        int nl  = iv ? (lo ^ (k % blk)) : ((lo + k) % blk);
        return 10'(sv - lo + nl);
    endfunction

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got vld/last/col=%h expected %h", req, act, exp);
        end
    endtask

    task automatic beat(input string req, input logic [9:0] s, input logic [2:0] l,
                        input logic iv, input int k);
        logic lst = (l != 3'd7) && (k == blen(l) - 1);
        chk(req, {col_vld, last_beat, col_out}, {1'b1, lst, exp_col(s, l, iv, k)});
    endtask

    task automatic idle(input string req);
        chk(req, {col_vld, last_beat, col_out}, 12'h000);
    endtask

    task automatic kick(input logic [9:0] s, input logic [2:0] l, input logic iv, input logic st);
        @(negedge clk);
        start = 1'b1; start_col = s; len_sel = l; ilv = iv; stop = st;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state, request during reset ignored
        repeat (2) @(negedge clk);
        idle("R1");
        start = 1'b1; start_col = 10'h123; len_sel = 3'd2;
        @(negedge clk);
        idle("R1");
        start = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        idle("R1 R11");

        // R3 R4 R5: table of bursts
        for (int v = 0; v < 8; v++) begin
            logic [9:0] s  = VEC[v][13:4];
            logic [2:0] l  = VEC[v][3:1];
            logic       iv = VEC[v][0];
            kick(s, l, iv, 1'b0);
            for (int k = 0; k < blen(l); k++) begin
                if (k > 0) @(negedge clk);
                beat(iv ? "R2 R4 R5" : "R2 R3 R5", s, l, iv, k);
            end
            @(negedge clk);
            idle("R5 R11");
        end

        // R6: full page across the wrap, then R7 stop
        kick(10'h3FC, 3'd7, 1'b0, 1'b0);
        for (int k = 0; k < 1030; k++) begin
            if (k > 0) @(negedge clk);
            beat("R6", 10'h3FC, 3'd7, 1'b0, k);
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        idle("R7");

        // R7: stop in the middle of a fixed burst
        kick(10'h010, 3'd3, 1'b0, 1'b0);
        beat("R7", 10'h010, 3'd3, 1'b0, 0);
        @(negedge clk); beat("R7", 10'h010, 3'd3, 1'b0, 1);
        @(negedge clk); beat("R7", 10'h010, 3'd3, 1'b0, 2);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        idle("R7");
        @(negedge clk);
        idle("R7");

        // R7: stop while idle
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        idle("R7");

        // R8: restart with new length and ordering
        kick(10'h020, 3'd3, 1'b0, 1'b0);
        beat("R8", 10'h020, 3'd3, 1'b0, 0);
        @(negedge clk); beat("R8", 10'h020, 3'd3, 1'b0, 1);
        kick(10'h155, 3'd2, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            beat("R8", 10'h155, 3'd2, 1'b1, k);
        end
        @(negedge clk);
        idle("R8");

        // R9: request and stop together
        kick(10'h020, 3'd3, 1'b0, 1'b0);
        beat("R9", 10'h020, 3'd3, 1'b0, 0);
        kick(10'h2A9, 3'd3, 1'b1, 1'b1);
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            beat("R9", 10'h2A9, 3'd3, 1'b1, k);
        end
        @(negedge clk);
        idle("R9");

        // R10: illegal requests while idle
        kick(10'h077, 3'd7, 1'b1, 1'b0);
        idle("R10");
        kick(10'h077, 3'd5, 1'b0, 1'b0);
        idle("R10");
        kick(10'h077, 3'd6, 1'b1, 1'b0);
        idle("R10");

        // R10: illegal request during a burst
        kick(10'h040, 3'd2, 1'b0, 1'b0);
        beat("R10", 10'h040, 3'd2, 1'b0, 0);
        @(negedge clk);
        beat("R10", 10'h040, 3'd2, 1'b0, 1);
        start = 1'b1; start_col = 10'h300; len_sel = 3'd7; ilv = 1'b1;
        @(negedge clk);
        start = 1'b0;
        beat("R10", 10'h040, 3'd2, 1'b0, 2);
        @(negedge clk);
        beat("R10", 10'h040, 3'd2, 1'b0, 3);
        @(negedge clk);
        idle("R10 R11");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule